// File: doc/BRIEF.md
# I2C SCL Timing Divider

This block turns a fast core clock into the SCL waveform of an I2C bus master. A timing word gives a power-of-two prescale exponent and separate counts for the high and low halves of the SCL period. The core clock is first divided by two to the power of the exponent. Each SCL phase then lasts a number of those prescaled ticks set by its own count. The bit engine that drives SDA gets two strobes: one at the start of every low phase, when SDA may change, and one in the middle of every high phase, when SDA is stable and can be sampled.

The block releases SCL and then waits for the sensed line to read high before it times the high phase. A slave that holds SCL low therefore stretches the clock with no loss of high time. A change to the timing word never cuts a phase short. The new word is taken on the clock edge that starts the next low phase. Deasserting the enable clears all counters and leaves SCL released.

Top module: `scl_timing_gen`

## Requirements
- R1: With B = timingWord[3:0], H = timingWord[19:16] and L = timingWord[15:12], each low phase (sclDriveLow = 1) lasts 2^B × (L+1) core cycles. Each high phase (sclDriveLow = 0, sensed line high throughout) lasts 2^B × (H+1) core cycles. B may take any value from 0 to 15.
- R2: Bits [31:20] and [11:4] of the timing word have no effect on the SCL waveform or on either strobe.
- R3: With the parameter CNT_W = 3, the high count is timingWord[18:16] and the low count is timingWord[14:12]. Bits 19 and 15 are then ignored, so each phase is at most 8 prescaled ticks long.
- R4: While SCL is released, a core cycle in which sclSense reads low does not count toward the high phase. A high phase held low for S cycles at its start lasts S + 2^B × (H+1) cycles.
- R5: launchTick is high for exactly one cycle per low phase: the first cycle in which sclDriveLow is 1.
- R6: sampleTick is high for exactly one cycle per high phase, and only while sclSense is high. That cycle comes after 2^B × floor((H+1)/2) counted high cycles, so on an unstretched high phase it is the cycle with 0-based index 2^B × floor((H+1)/2).
- R7: The timing word is sampled only on the edge that begins a low phase. A phase already running keeps its old length. A word changed during a low phase first shapes the low phase after the next high phase.
- R8: In the cycle after enable falls, sclDriveLow and launchTick are 0, and sampleTick is 0 whenever enable is 0. After enable rises again, the first low phase begins 2^B × (H+1) cycles later.
- R9: While rstN is low, sclDriveLow and launchTick are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the generator. When low, counters are cleared and SCL is released |
| timingWord | input | 32 | Prescale exponent [3:0], low count [15:12], high count [19:16] |
| sclSense | input | 1 | Sensed level of the real SCL line |
| sclDriveLow | output | 1 | 1 pulls SCL low, 0 releases it |
| sampleTick | output | 1 | One-cycle strobe in the middle of the high phase |
| launchTick | output | 1 | One-cycle strobe at the start of the low phase |

## Verification
The reload of the timing word and the high-to-low phase change share one clock edge by design. The bench makes the word change coincide with both ends of a phase. In one case it writes a new word in the last cycle of a two-cycle low phase. In the other it writes the word partway through a high phase. It then measures the next three phase lengths. Only the reload-at-low-start rule gives the old, old, new order after a change during a low phase, and old, new, new after a change during a high phase. The bench also overlaps clock stretching with the mid-high sample point, and expects the sample strobe to move later by exactly the stretch.

// File: rtl/sclt_pkg.sv
package sclt_pkg;

  // strobes from the phase control to the counter datapath
  typedef struct packed {
    logic clear;    // drop counters, track the timing word
    logic advance;  // count this core cycle
    logic reload;   // take a new timing word
  } ctlStrobe_t;

  // conditions reported by the datapath
  typedef struct packed {
    logic preWrap;  // prescaler at its last count
    logic phaseEnd; // last core cycle of the current phase
    logic atMid;    // first core cycle of the mid tick of the high phase
  } dpStatus_t;

endpackage

// File: rtl/sclt_datapath.sv
module sclt_datapath
  import sclt_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int CNT_W    = 4,
  parameter int BASE_W   = 4,
  parameter int HIGH_LSB = 16,
  parameter int LOW_LSB  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic              phaseHigh,
  input  logic [WORD_W-1:0] timingWord,
  output dpStatus_t         st
);

  localparam int PRE_W = (1 << BASE_W) - 1;
  localparam logic [WORD_W-1:0] CNT_ONES  = WORD_W'((1 << CNT_W) - 1);
  localparam logic [WORD_W-1:0] BASE_ONES = WORD_W'((1 << BASE_W) - 1);
  localparam logic [WORD_W-1:0] USED_MASK =
    (CNT_ONES << HIGH_LSB) | (CNT_ONES << LOW_LSB) | BASE_ONES;

  logic [BASE_W-1:0] wordBase, actBase;
  logic [CNT_W-1:0]  wordHigh, wordLow, actHigh, actLow;
  logic [PRE_W-1:0]  preCnt, preMax;
  logic [PRE_W:0]    preLimitWide;
  logic [CNT_W-1:0]  phaseCnt, phaseLim, midCnt;
  logic [CNT_W:0]    highPlus;
  logic              unusedBits;

  // field pick-off; the count width selects the variant
  assign wordBase = timingWord[0 +: BASE_W];
  assign wordHigh = timingWord[HIGH_LSB +: CNT_W];
  assign wordLow  = timingWord[LOW_LSB +: CNT_W];
  assign unusedBits = ^(timingWord & ~USED_MASK);

  // prescaler limit: 2^base - 1
  assign preLimitWide = ({{PRE_W{1'b0}}, 1'b1} << actBase) - 1'b1;
  assign preMax       = preLimitWide[PRE_W-1:0];

  assign phaseLim = phaseHigh ? actHigh : actLow;
  assign highPlus = {1'b0, actHigh} + 1'b1;
  assign midCnt   = highPlus[CNT_W:1];

  assign st.preWrap  = (preCnt == preMax);
  assign st.phaseEnd = st.preWrap && (phaseCnt == phaseLim);
  assign st.atMid    = (preCnt == '0) && (phaseCnt == midCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actBase  <= '0;
      actHigh  <= '0;
      actLow   <= '0;
      preCnt   <= '0;
      phaseCnt <= '0;
    end else if (ctl.clear) begin
      actBase  <= wordBase;
      actHigh  <= wordHigh;
      actLow   <= wordLow;
      preCnt   <= '0;
      phaseCnt <= '0;
    end else begin
      if (ctl.reload) begin
        actBase <= wordBase;
        actHigh <= wordHigh;
        actLow  <= wordLow;
      end
      if (ctl.advance) begin
        if (st.preWrap) begin
          preCnt   <= '0;
          phaseCnt <= st.phaseEnd ? '0 : phaseCnt + 1'b1;
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sclt_control.sv
module sclt_control
  import sclt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       sclSense,
  input  dpStatus_t  st,
  output ctlStrobe_t ctl,
  output logic       phaseHigh,
  output logic       sampleTick,
  output logic       launchTick
);

  logic phaseFlip;

  // a released phase only counts once the line is really high
  assign ctl.clear   = !enable;
  assign ctl.advance = enable && (!phaseHigh || sclSense);
  assign phaseFlip   = ctl.advance && st.phaseEnd;
  assign ctl.reload  = phaseFlip && phaseHigh;

  assign sampleTick = phaseHigh && ctl.advance && st.atMid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseHigh  <= 1'b1;
      launchTick <= 1'b0;
    end else if (!enable) begin
      phaseHigh  <= 1'b1;
      launchTick <= 1'b0;
    end else begin
      if (phaseFlip) phaseHigh <= !phaseHigh;
      launchTick <= phaseFlip && phaseHigh;
    end
  end

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import sclt_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int CNT_W    = 4,
  parameter int BASE_W   = 4,
  parameter int HIGH_LSB = 16,
  parameter int LOW_LSB  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [WORD_W-1:0] timingWord,
  input  logic              sclSense,
  output logic              sclDriveLow,
  output logic              sampleTick,
  output logic              launchTick
);

  ctlStrobe_t ctl;
  dpStatus_t  st;
  logic       phaseHigh;

  sclt_control uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .sclSense   (sclSense),
    .st         (st),
    .ctl        (ctl),
    .phaseHigh  (phaseHigh),
    .sampleTick (sampleTick),
    .launchTick (launchTick)
  );

  sclt_datapath #(
    .WORD_W   (WORD_W),
    .CNT_W    (CNT_W),
    .BASE_W   (BASE_W),
    .HIGH_LSB (HIGH_LSB),
    .LOW_LSB  (LOW_LSB)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .phaseHigh  (phaseHigh),
    .timingWord (timingWord),
    .st         (st)
  );

  assign sclDriveLow = !phaseHigh;

endmodule

// File: rtl/sclt_checker.sv
module sclt_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic sclSense,
  input logic sclDriveLow,
  input logic sampleTick,
  input logic launchTick
);

  // R8: released and quiet one cycle after enable drops
  a_r8_release: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sclDriveLow && !launchTick));

  // R8: no sample strobe while disabled
  a_r8_no_sample: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !sampleTick);

  // R5: launch strobe only on the first low cycle
  a_r5_launch_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    launchTick |-> $rose(sclDriveLow));

  // R5: every low phase announces itself
  a_r5_fall_has_launch: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclDriveLow) |-> launchTick);

  // R6: sampling only during a high, sensed-high cycle
  a_r6_sample_in_high: assert property (@(posedge clk) disable iff (!rstN)
    sampleTick |-> (!sclDriveLow && sclSense));

  // R4: a held-low line keeps the high phase open
  a_r4_hold_while_low: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !sclDriveLow && !sclSense) |=> !sclDriveLow);

endmodule

bind scl_timing_gen sclt_checker uChk (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .sclSense    (sclSense),
  .sclDriveLow (sclDriveLow),
  .sampleTick  (sampleTick),
  .launchTick  (launchTick)
);

// File: tb/sim_scl_timing_gen.sv
`timescale 1ns/1ps
module sim_scl_timing_gen;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable0 = 1'b0, enable1 = 1'b0;
  logic [31:0] word0 = '0, word1 = '0;
  logic holdLow0 = 1'b0;
  logic sense0, sense1, drive0, drive1, smp0, smp1, lch0, lch1;
  logic sel = 1'b0;
  logic curDrive, curSmp, curLch;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam int NV = 7;
  localparam logic [31:0] VWORD [NV] = '{32'h0000_0000, 32'h0003_5001,
    32'hFFF0_0FF2, 32'h000F_F000, 32'h0007_2003, 32'h0001_E006, 32'h0000_000F};
  localparam int VLOW  [NV] = '{1, 12, 4, 16, 24, 960, 32768};
  localparam int VHIGH [NV] = '{1, 8, 4, 16, 64, 128, 32768};
  localparam int VSMP  [NV] = '{0, 4, 0, 8, 32, 64, 0};

  localparam logic [31:0] WA = 32'h0002_2001; // low 6, high 6
  localparam logic [31:0] WB = 32'h0007_1000; // low 2, high 8

  assign sense0 = !drive0 && !holdLow0;
  assign sense1 = !drive1;
  assign curDrive = sel ? drive1 : drive0;
  assign curSmp   = sel ? smp1 : smp0;
  assign curLch   = sel ? lch1 : lch0;

  always #2.5 clk = ~clk;

  scl_timing_gen u0 (
    .clk(clk), .rstN(rstN), .enable(enable0), .timingWord(word0),
    .sclSense(sense0), .sclDriveLow(drive0), .sampleTick(smp0),
    .launchTick(lch0));

  scl_timing_gen #(.CNT_W(3)) u1 (
    .clk(clk), .rstN(rstN), .enable(enable1), .timingWord(word1),
    .sclSense(sense1), .sclDriveLow(drive1), .sampleTick(smp1),
    .launchTick(lch1));

  task automatic expectEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic setWord(input logic [31:0] w);
    if (sel) word1 = w; else word0 = w;
  endtask

  task automatic restart(input logic [31:0] w);
    @(negedge clk);
    if (sel) enable1 = 1'b0; else enable0 = 1'b0;
    setWord(w);
    @(negedge clk);
    if (sel) enable1 = 1'b1; else enable0 = 1'b1;
  endtask

  task automatic waitLowStart();
    logic prev;
    prev = curDrive;
    @(negedge clk);
    while (!(prev == 1'b0 && curDrive == 1'b1)) begin
      prev = curDrive;
      @(negedge clk);
    end
  endtask

  // measures the run of the given level starting at the current negedge
  task automatic runLen(input logic lvl, input int changeAt, input logic [31:0] newWord,
                        input int releaseAt, output int n, output int sIdx,
                        output int sCnt, output int lIdx, output int lCnt);
    n = 0; sIdx = -1; sCnt = 0; lIdx = -1; lCnt = 0;
    while (curDrive == lvl && n < 70000) begin
      if (curSmp) begin if (sCnt == 0) sIdx = n; sCnt++; end
      if (curLch) begin if (lCnt == 0) lIdx = n; lCnt++; end
      if (n == changeAt) setWord(newWord);
      if (n == releaseAt) holdLow0 = 1'b0;
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    int n, sI, sC, lI, lC;
    // R9: reset holds the outputs quiet even with enable high
    enable0 = 1'b1;
    repeat (3) @(negedge clk);
    expectEq("R9", "drive in reset", int'(drive0), 0);
    expectEq("R9", "launch in reset", int'(lch0), 0);
    enable0 = 1'b0;
    @(negedge clk);
    rstN = 1'b1;

    // R1 R2 R5 R6: vector table
    for (int v = 0; v < NV; v++) begin
      restart(VWORD[v]);
      waitLowStart();
      runLen(1'b1, -1, '0, -1, n, sI, sC, lI, lC);
      expectEq("R1", $sformatf("v%0d low length", v), n, VLOW[v]);
      expectEq("R5", $sformatf("v%0d launch index", v), lI, 0);
      expectEq("R5", $sformatf("v%0d launch count", v), lC, 1);
      runLen(1'b0, -1, '0, -1, n, sI, sC, lI, lC);
      expectEq("R1", $sformatf("v%0d high length", v), n, VHIGH[v]);
      expectEq("R6", $sformatf("v%0d sample index", v), sI, VSMP[v]);
      expectEq("R6", $sformatf("v%0d sample count", v), sC, 1);
    end

    // R2: upper and middle bits toggled mid-run have no effect
    restart(32'h0003_5001);
    waitLowStart();
    runLen(1'b1, 3, 32'hABC3_5A51, -1, n, sI, sC, lI, lC);
    runLen(1'b0, -1, '0, -1, n, sI, sC, lI, lC);
    runLen(1'b1, -1, '0, -1, n, sI, sC, lI, lC);
    expectEq("R2", "low after ignored-bit change", n, 12);
    runLen(1'b0, -1, '0, -1, n, sI, sC, lI, lC);
    expectEq("R2", "high after ignored-bit change", n, 8);

    // R4: stretch 5 cycles at the start of a high phase
    restart(32'h0001_3000);
    waitLowStart();
    runLen(1'b1, -1, '0, -1, n, sI, sC, lI, lC);
    expectEq("R4", "low before stretch", n, 4);
    holdLow0 = 1'b1;
    runLen(1'b0, -1, '0, 5, n, sI, sC, lI, lC);
    expectEq("R4", "stretched high length", n, 7);
    expectEq("R6", "stretched sample index", sI, 6);
    expectEq("R6", "stretched sample count", sC, 1);

    // R7: change during high phase
    restart(WA);
    waitLowStart();
    runLen(1'b1, -1, '0, -1, n, sI, sC, lI, lC);
    expectEq("R7", "low A", n, 6);
    runLen(1'b0, 2, WB, -1, n, sI, sC, lI, lC);
    expectEq("R7", "running high keeps A", n, 6);
    runLen(1'b1, -1, '0, -1, n, sI, sC, lI, lC);
    expectEq("R7", "next low takes B", n, 2);
    runLen(1'b0, -1, '0, -1, n, sI, sC, lI, lC);
    expectEq("R7", "next high takes B", n, 8);
    // R7: change in the last cycle of a low phase
    runLen(1'b1, 1, WA, -1, n, sI, sC, lI, lC);
    expectEq("R7", "running low keeps B", n, 2);
    runLen(1'b0, -1, '0, -1, n, sI, sC, lI, lC);
    expectEq("R7", "following high keeps B", n, 8);
    runLen(1'b1, -1, '0, -1, n, sI, sC, lI, lC);
    expectEq("R7", "low after that takes A", n, 6);
    runLen(1'b0, -1, '0, -1, n, sI, sC, lI, lC);
    expectEq("R7", "high after that takes A", n, 6);

    // R8: disable in the middle of a low phase
    waitLowStart();
    @(negedge clk);
    enable0 = 1'b0;
    @(negedge clk);
    expectEq("R8", "drive after disable", int'(drive0), 0);
    begin
      int bad = 0;
      repeat (5) begin
        @(negedge clk);
        if (drive0 || smp0 || lch0) bad++;
      end
      expectEq("R8", "quiet cycles while disabled", bad, 0);
    end
    enable0 = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!drive0 && n < 1000);
    expectEq("R8", "first low after re-enable", n, 6);

    // R3: narrow variant ignores bits 19 and 15
    sel = 1'b1;
    restart(32'h000F_F000);
    waitLowStart();
    runLen(1'b1, -1, '0, -1, n, sI, sC, lI, lC);
    expectEq("R3", "narrow low cap", n, 8);
    runLen(1'b0, -1, '0, -1, n, sI, sC, lI, lC);
    expectEq("R3", "narrow high cap", n, 8);
    restart(32'h0008_8000);
    waitLowStart();
    runLen(1'b1, -1, '0, -1, n, sI, sC, lI, lC);
    expectEq("R3", "narrow low, bit 15 ignored", n, 1);
    runLen(1'b0, -1, '0, -1, n, sI, sC, lI, lC);
    expectEq("R3", "narrow high, bit 19 ignored", n, 1);

    summary();
  end

endmodule